// File: doc/BRIEF.md
# AES Encryption Round Unit

This unit performs one forward AES cipher round on a 128-bit state. A single flag selects between the two round flavours. A normal round applies byte substitution, the row rotation, the column mixing and the key addition. A final round drops the column mixing. The result is the new 128-bit state. A cipher engine calls the unit once per round, each time with that round's key, and sets the flag only on the closing round.

The datapath is purely combinational. Sixteen independent substitution boxes each derive their value from the field inverse and an affine map, so no lookup table is stored. A parameter places a register on the output, which gives one cycle of latency, or leaves the path combinational. A small controller turns the flag into strobes for the datapath.

Top module: `aesEncRound`

## Requirements
- R1: Each of the 16 state bytes is substituted on its own by the AES forward S-box. The box maps 0x00 to 0x63, 0x01 to 0x7c, 0x10 to 0xca and 0xff to 0x16.
- R2: Byte k of a 128-bit bus is bits [8k+7:8k] and sits at row k%4, column k/4. After substitution, row r is rotated left by r byte positions: new(r,c) = old(r,(c+r)%4). Row 0 is unchanged.
- R3: When `lastRound`=0, each column [a0,a1,a2,a3] after the rotation is replaced by the product with the circulant matrix of rows (02,03,01,01), (01,02,03,01), (01,01,02,03) and (03,01,01,02) over GF(2^8) modulo x^8+x^4+x^3+x+1. A column of four equal bytes therefore stays unchanged.
- R4: When `lastRound`=1, the column mixing is bypassed. The output is the rotated, substituted state XOR the key. Normal and final rounds may alternate on consecutive cycles.
- R5: The round key is added as a bitwise XOR of all 128 bits, after all other steps.
- R6: With `REG_OUT`=1 (the default), `stateOut` shows the round result for the inputs present at the previous rising clock edge. While `rstN`=0, `stateOut` is 0. With `REG_OUT`=0, `stateOut` is combinational.
- R7: A normal round on state bytes 19 3d e3 be a0 f4 e2 2b 9a c6 8d 2a e9 f8 48 08, with key bytes a0 fa fe 17 88 54 2c b1 23 a3 39 39 2a 6c 76 05, yields a4 9c 7f f2 68 9f 35 2b 6b 5b ea 43 02 6a 50 49. In each list, byte 0 comes first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| stateIn | input | 128 | State entering the round, byte k at bits [8k+7:8k] |
| roundKey | input | 128 | Round key, same byte layout |
| lastRound | input | 1 | 1 selects a final round (no column mixing) |
| stateOut | output | 128 | New state after the round |

## Verification
The column-mixing bypass and the key addition both act in every cycle. A change of the round flavour can therefore land in the same cycle as a new state and key. The bench provokes this with back-to-back vectors that flip `lastRound` on every cycle while state and key also change. Each result is compared one cycle later against a bench model that builds its own S-box by searching for field inverses. Any leak of the previous cycle's flavour, or a mixed column left in a final round, shows up as a miscompare.

// File: rtl/aesRoundPkg.sv
package aesRoundPkg;
  localparam int ROW_CNT  = 4;
  localparam int COL_CNT  = 4;
  localparam int BYTE_W   = 8;
  localparam int BYTE_CNT = ROW_CNT * COL_CNT;
  localparam int STATE_W  = BYTE_CNT * BYTE_W;
  localparam logic [7:0] AFFINE_C = 8'h63;
  localparam logic [7:0] FIELD_POLY = 8'h1b;

  typedef struct packed {
    logic bypassMix;
    logic loadOut;
  } roundStrobes_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? FIELD_POLY : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] run;
    acc = 8'h00;
    run = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ run;
      run = xtime(run);
    end
    return acc;
  endfunction

  // a^254 equals the multiplicative inverse, and 0 maps to 0
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] pw;
    logic [7:0] res;
    pw  = a;
    res = 8'h01;
    for (int i = 1; i < 8; i++) begin
      pw  = gfMul(pw, pw);
      res = gfMul(res, pw);
    end
    return res;
  endfunction

  function automatic logic [7:0] sboxCalc(input logic [7:0] a);
    logic [7:0] v;
    v = gfInv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ AFFINE_C;
  endfunction

  function automatic logic [7:0] mixByte(input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] c, input logic [7:0] d);
    return xtime(a) ^ xtime(b) ^ b ^ c ^ d;
  endfunction
endpackage

// File: rtl/aesSboxByte.sv
module aesSboxByte
  import aesRoundPkg::*;
(
  input  logic [BYTE_W-1:0] byteIn,
  output logic [BYTE_W-1:0] byteOut
);
  always_comb byteOut = sboxCalc(byteIn);
endmodule

// File: rtl/aesRoundCtrl.sv
module aesRoundCtrl
  import aesRoundPkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          lastRound,
  output roundStrobes_t strb
);
  always_comb begin
    strb.bypassMix = lastRound;
    strb.loadOut   = REG_OUT;
  end
endmodule

// File: rtl/aesRoundDatapath.sv
module aesRoundDatapath
  import aesRoundPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] stateIn,
  input  logic [STATE_W-1:0] roundKey,
  input  roundStrobes_t      strb,
  output logic [STATE_W-1:0] roundOut
);
  logic [STATE_W-1:0] subState;
  logic [STATE_W-1:0] shiftState;
  logic [STATE_W-1:0] mixState;
  logic [STATE_W-1:0] preKey;

  for (genvar k = 0; k < BYTE_CNT; k++) begin : gSub
    aesSboxByte uBox (
      .byteIn (stateIn[BYTE_W*k +: BYTE_W]),
      .byteOut(subState[BYTE_W*k +: BYTE_W])
    );
  end

  for (genvar c = 0; c < COL_CNT; c++) begin : gCol
    for (genvar r = 0; r < ROW_CNT; r++) begin : gRow
      localparam int DST = ROW_CNT * c + r;
      localparam int SRC = ROW_CNT * ((c + r) % COL_CNT) + r;
      localparam int B1  = ROW_CNT * c + (r + 1) % ROW_CNT;
      localparam int B2  = ROW_CNT * c + (r + 2) % ROW_CNT;
      localparam int B3  = ROW_CNT * c + (r + 3) % ROW_CNT;
      assign shiftState[BYTE_W*DST +: BYTE_W] = subState[BYTE_W*SRC +: BYTE_W];
      assign mixState[BYTE_W*DST +: BYTE_W] =
        mixByte(shiftState[BYTE_W*DST +: BYTE_W], shiftState[BYTE_W*B1 +: BYTE_W],
                shiftState[BYTE_W*B2 +: BYTE_W], shiftState[BYTE_W*B3 +: BYTE_W]);
    end
  end

  always_comb begin
    preKey   = strb.bypassMix ? shiftState : mixState;
    roundOut = preKey ^ roundKey;
  end

  // R1: a zero input byte substitutes to 0x63
  assert_sbox_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stateIn[7:0] == 8'h00) |-> (subState[7:0] == 8'h63));

  // R2: row 0 bytes keep their column across the rotation
  assert_row0_fixed_R2: assert property (@(posedge clk) disable iff (!rstN)
    (shiftState[7:0] == subState[7:0]) && (shiftState[39:32] == subState[39:32]) &&
    (shiftState[71:64] == subState[71:64]) && (shiftState[103:96] == subState[103:96]));

  // R3: a uniform column is a fixed point of the mixing
  assert_mix_uniform_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.bypassMix && shiftState[7:0] == shiftState[15:8] &&
     shiftState[15:8] == shiftState[23:16] && shiftState[23:16] == shiftState[31:24])
    |-> (roundOut[31:0] == (shiftState[31:0] ^ roundKey[31:0])));

  // R4: a final round carries the rotated state straight to the key addition
  assert_bypass_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.bypassMix |-> ((roundOut ^ roundKey) == shiftState));
endmodule

// File: rtl/aesEncRound.sv
module aesEncRound
  import aesRoundPkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] stateIn,
  input  logic [STATE_W-1:0] roundKey,
  input  logic               lastRound,
  output logic [STATE_W-1:0] stateOut
);
  roundStrobes_t      strb;
  logic [STATE_W-1:0] roundOut;

  aesRoundCtrl #(.REG_OUT(REG_OUT)) uCtrl (
    .lastRound(lastRound),
    .strb     (strb)
  );

  aesRoundDatapath uPath (
    .clk     (clk),
    .rstN    (rstN),
    .stateIn (stateIn),
    .roundKey(roundKey),
    .strb    (strb),
    .roundOut(roundOut)
  );

  if (REG_OUT) begin : gReg
    logic [STATE_W-1:0] outReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outReg <= '0;
      else if (strb.loadOut) outReg <= roundOut;
    end
    assign stateOut = outReg;
  end else begin : gComb
    assign stateOut = roundOut;
  end
endmodule

// File: tb/tb_aesEncRound.sv
module tb_aesEncRound;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [127:0] stateIn = '0;
  logic [127:0] roundKey = '0;
  logic         lastRound = 1'b0;
  logic [127:0] stateOut;

  int vecCount = 0;
  int missCount = 0;
  logic [127:0] expQ[$];
  string        tagQ[$];
  logic [7:0]   refBox[256];

  aesEncRound dut (
    .clk(clk), .rstN(rstN), .stateIn(stateIn), .roundKey(roundKey),
    .lastRound(lastRound), .stateOut(stateOut)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] tbMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 8'h00;
    logic [7:0] sh = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= sh;
      sh = sh[7] ? ((sh << 1) ^ 8'h1b) : (sh << 1);
    end
    return acc;
  endfunction

  function automatic logic [127:0] bswap(input logic [127:0] v);
    logic [127:0] o;
    for (int k = 0; k < 16; k++) o[8*k +: 8] = v[8*(15-k) +: 8];
    return o;
  endfunction

  function automatic logic [127:0] refRound(input logic [127:0] s, input logic [127:0] key,
                                             input logic last);
    logic [7:0] sb[16];
    logic [7:0] sr[16];
    logic [127:0] o;
    for (int k = 0; k < 16; k++) sb[k] = refBox[s[8*k +: 8]];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) sr[4*c + r] = sb[4*((c + r) % 4) + r];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        if (last) o[8*(4*c + r) +: 8] = sr[4*c + r];
        else o[8*(4*c + r) +: 8] = tbMul(8'h02, sr[4*c + r]) ^
                                   tbMul(8'h03, sr[4*c + (r+1)%4]) ^
                                   sr[4*c + (r+2)%4] ^ sr[4*c + (r+3)%4];
      end
    return o ^ key;
  endfunction

  task automatic pushVec(input logic [127:0] s, input logic [127:0] k, input logic last,
                         input logic [127:0] expv, input string tag);
    @(negedge clk);
    stateIn = s; roundKey = k; lastRound = last;
    expQ.push_back(expv);
    tagQ.push_back(tag);
  endtask

  task automatic pushRef(input logic [127:0] s, input logic [127:0] k, input logic last,
                         input string tag);
    pushVec(s, k, last, refRound(s, k, last), tag);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        logic [127:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        vecCount++;
        if (stateOut !== e) begin
          missCount++;
          $display("FAIL %s: got %h expected %h", t, stateOut, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    missCount++;
    $display("FAIL watchdog: run hung, got 0 expected 1");
    finishRun();
  end

  initial begin : driver
    logic [7:0] inv;
    for (int a = 0; a < 256; a++) begin
      logic [7:0] x;
      inv = 8'h00;
      for (int b = 1; b < 256; b++) if (tbMul(a[7:0], b[7:0]) == 8'h01) inv = b[7:0];
      for (int i = 0; i < 8; i++)
        x[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
      refBox[a] = x;
    end

    stateIn = {16{8'hff}};
    repeat (3) @(negedge clk);
    vecCount++;
    if (stateOut !== '0) begin
      missCount++;
      $display("FAIL R6 reset: got %h expected %h", stateOut, 128'h0);
    end
    rstN = 1'b1;

    // R1: known S-box values, final round and zero key
    pushVec({16{8'h00}}, '0, 1'b1, {16{8'h63}}, "R1 00->63");
    pushVec({16{8'h01}}, '0, 1'b1, {16{8'h7c}}, "R1 01->7c");
    pushVec({16{8'h10}}, '0, 1'b1, {16{8'hca}}, "R1 10->ca");
    pushVec({16{8'hff}}, '0, 1'b1, {16{8'h16}}, "R1 ff->16");
    // R5: key XOR on a known result
    pushVec('0, 128'h0123456789abcdef_fedcba9876543210, 1'b1,
            {16{8'h63}} ^ 128'h0123456789abcdef_fedcba9876543210, "R5 key xor");
    // R3: uniform columns stay fixed in a normal round
    pushVec({16{8'h00}}, '0, 1'b0, {16{8'h63}}, "R3 uniform column");
    // R2: distinct bytes expose the rotation
    pushRef(128'h0f0e0d0c0b0a09080706050403020100, '0, 1'b1, "R2 rotation");
    pushRef(128'h0f0e0d0c0b0a09080706050403020100, '0, 1'b0, "R3 mix on ramp");
    // R7: known normal round
    pushVec(bswap(128'h193de3bea0f4e22b9ac68d2ae9f84808),
            bswap(128'ha0fafe1788542cb123a339392a6c7605), 1'b0,
            bswap(128'ha49c7ff2689f352b6b5bea43026a5049), "R7 known round");
    // R4: flavour flips every cycle with changing data
    for (int n = 0; n < 40; n++) begin
      logic [127:0] s;
      logic [127:0] k;
      s = {$urandom, $urandom, $urandom, $urandom};
      k = {$urandom, $urandom, $urandom, $urandom};
      pushRef(s, k, n[0], n[0] ? "R4 final round" : "R3 normal round");
    end
    // R6: output returns to zero under reset
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    vecCount++;
    if (stateOut !== '0) begin
      missCount++;
      $display("FAIL R6 async clear: got %h expected %h", stateOut, 128'h0);
    end
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule